// File: doc/BRIEF.md
# Channelized Programmable Frequency Divider

The block sits in the digital half of a 27 MHz band synthesizer loop. A channel number arrives on an 8-bit parallel bus and a transmit/receive select picks the operating mode. From these the block looks up a receive divide ratio N in a built-in 40-channel table. In transmit mode it adds a fixed offset of 91, which moves the VCO by 455 kHz. It then divides the VCO feedback by N, so that the loop settles at N × 5 kHz. A second, fixed divider turns a faster reference into the same 5 kHz comparison rate. Both divided pulse trains go to an external phase comparator.

Everything runs on one sampling clock. The VCO and reference edges come in as one-cycle tick strobes. A digital lock indicator compares the two divided pulse trains against a window, given in sampling-clock cycles, that is set on an input port. An invalid channel code never disturbs the running loop: the last valid divisor stays in force and the lock indicator is pulled low.

Top module: `chdiv_synth`

## Requirements
- R1: With `variant` 0 and `tx_mode` low, a channel code in binary 1..40 selects a receive divisor of 3254 + 2·s. Here s is the channel's 10 kHz slot: s = ch−1 plus one extra slot for each of the boundaries ch≥4, 8, 12, 16, 20 (up to channel 22). Channel 23 has slot 29, 24 has 27, 25 has 28, and channels 26..40 have ch+4. For example, channel 1 gives 3254, 2 gives 3256, 22 gives 3306, 23 gives 3312, 24 gives 3308 and 40 gives 3342.
- R2: With `tx_mode` high, the divisor is the receive divisor plus 91. For example, channel 1 gives 3345 and channel 40 gives 3433 in the standard table.
- R3: With parameter `VARIANT` = 1, the receive divisor is 3381 + 2·(ch−1): 3381, 3383 … 3459. Transmit adds 91, so channel 40 transmits with 3550.
- R4: A code of 0 or above 40 leaves the divisor at the last valid channel's value.
- R5: An invalid code drives `lock` low within two clock edges.
- R6: A new divisor, from a channel or mode change, is loaded only at the divider's terminal count. The period in progress completes with the old N.
- R7: `fb_pulse` is high for exactly one cycle for every N `vco_tick` strobes. The first strobe after reset produces a pulse, so the period in clock cycles scales with the strobe rate.
- R8: `ref_pulse` is high for one cycle every REF_CLK_HZ/STEP_HZ `ref_tick` strobes.
- R9: `lock` rises after 16 consecutive comparison periods in which the feedback pulse falls within `lock_window` cycles of the reference pulse, on either side.
- R10: `lock` falls on the first comparison period whose pulses are more than `lock_window` cycles apart.
- R11: After reset, both pulse outputs and `lock` are low and the divisor is that of channel 1 receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_code | input | 8 | Binary channel number, valid 1..40 |
| tx_mode | input | 1 | High selects transmit, low selects receive |
| vco_tick | input | 1 | One-cycle strobe per VCO feedback edge |
| ref_tick | input | 1 | One-cycle strobe per reference edge |
| lock_window | input | WIN_W | Allowed pulse separation in clock cycles |
| fb_pulse | output | 1 | Divided VCO pulse, one cycle wide |
| ref_pulse | output | 1 | Divided reference pulse, one cycle wide |
| lock | output | 1 | High while the loop is judged locked |

## Verification
A channel or mode change reaches the divisor request one edge after it is applied. It then waits for the next terminal count, so the bench sets new inputs and ignores the interval that is already running. The period it measures is the one between the loading pulse and the pulse after it, counted in whole cycles at falling edges. Pulse outputs are registered, so each appears one edge after the terminal-count strobe. A lock decision lands one edge after the period that decides it, and a forced unlock lands two edges after a bad code, so lock checks sample three cycles after the deciding pulse or code change. Lock drift is produced by a channel change of one step, which moves the feedback 2 cycles per period against the reference. The bench therefore knows which period first leaves a window of 4.

// File: rtl/chdiv_pkg.sv
package chdiv_pkg;
  localparam int CODE_W    = 8;
  localparam int CH_FIRST  = 1;
  localparam int CH_LAST   = 40;
  localparam int DIV_W     = 12;
  localparam int TX_OFFSET = 91;
  localparam int BASE_STD  = 3254;
  localparam int BASE_ALT  = 3381;

  // 10 kHz slot of a channel in the standard (gapped, reordered) plan
  function automatic int unsigned std_slot(input int unsigned ch);
    int unsigned s;
    if (ch <= 22)
      s = (ch - 1) + (ch >= 4 ? 1 : 0) + (ch >= 8 ? 1 : 0) + (ch >= 12 ? 1 : 0)
        + (ch >= 16 ? 1 : 0) + (ch >= 20 ? 1 : 0);
    else if (ch == 23) s = 29;
    else if (ch == 24) s = 27;
    else if (ch == 25) s = 28;
    else               s = ch + 4;
    return s;
  endfunction

  function automatic logic [DIV_W-1:0] rx_div(input int variant, input int unsigned ch);
    int unsigned v;
    if (variant == 0) v = BASE_STD + 2 * std_slot(ch);
    else              v = BASE_ALT + 2 * (ch - 1);
    return DIV_W'(v);
  endfunction

  function automatic logic code_ok(input logic [CODE_W-1:0] c);
    return (c >= CODE_W'(CH_FIRST)) && (c <= CODE_W'(CH_LAST));
  endfunction
endpackage

// File: rtl/chdiv_select.sv
module chdiv_select
  import chdiv_pkg::*;
#(
  parameter int VARIANT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] ch_code,
  input  logic              tx_mode,
  output logic [DIV_W-1:0]  div_req,
  output logic              code_bad,
  output logic [CODE_W-1:0] held_ch
);
  logic              ok;
  logic [CODE_W-1:0] ch_next;

  always_comb begin
    ok      = code_ok(ch_code);
    ch_next = ok ? ch_code : held_ch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_ch  <= CODE_W'(CH_FIRST);
      div_req  <= rx_div(VARIANT, CH_FIRST);
      code_bad <= 1'b0;
    end else begin
      held_ch  <= ch_next;
      code_bad <= !ok;
      div_req  <= rx_div(VARIANT, 32'(ch_next)) + (tx_mode ? DIV_W'(TX_OFFSET) : '0);
    end
  end
endmodule

// File: rtl/chdiv_counter.sv
module chdiv_counter #(
  parameter int           W        = 12,
  parameter logic [W-1:0] INIT_DIV = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] div_in,
  output logic         pulse,
  output logic         tc,
  output logic [W-1:0] cur_div,
  output logic [W-1:0] remaining
);
  assign tc = tick && (remaining == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remaining <= '0;
      cur_div   <= INIT_DIV;
      pulse     <= 1'b0;
    end else begin
      pulse <= tc;
      if (tc) begin
        remaining <= div_in - W'(1);
        cur_div   <= div_in;
      end else if (tick) begin
        remaining <= remaining - W'(1);
      end
    end
  end
endmodule

// File: rtl/chdiv_lock.sv
module chdiv_lock #(
  parameter int WIN_W    = 4,
  parameter int LOCK_RUN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fb_p,
  input  logic             ref_p,
  input  logic             force_low,
  input  logic [WIN_W-1:0] window,
  output logic             locked,
  output logic             good_evt,
  output logic             bad_evt
);
  localparam int               AGE_W   = WIN_W + 1;
  localparam int               RUN_W   = $clog2(LOCK_RUN + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(LOCK_RUN);

  logic [AGE_W-1:0] fb_age, ref_age, fb_now, ref_now, win_ext;
  logic [RUN_W-1:0] streak, streak_n;
  logic             waiting, wait_n;

  always_comb begin
    win_ext  = {1'b0, window};
    fb_now   = fb_p  ? '0 : fb_age;
    ref_now  = ref_p ? '0 : ref_age;
    good_evt = 1'b0;
    bad_evt  = 1'b0;
    wait_n   = waiting;
    if (ref_p) begin
      bad_evt = waiting;
      if (fb_now <= win_ext) begin
        good_evt = 1'b1;
        wait_n   = 1'b0;
      end else begin
        wait_n = 1'b1;
      end
    end else if (waiting) begin
      if (fb_p && (ref_now <= win_ext)) begin
        good_evt = 1'b1;
        wait_n   = 1'b0;
      end else if (ref_now > win_ext) begin
        bad_evt = 1'b1;
        wait_n  = 1'b0;
      end
    end
    streak_n = bad_evt ? '0 : streak;
    if (good_evt && (streak_n != RUN_MAX)) streak_n = streak_n + RUN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_age  <= AGE_MAX;
      ref_age <= AGE_MAX;
      streak  <= '0;
      locked  <= 1'b0;
      waiting <= 1'b0;
    end else begin
      fb_age  <= fb_p  ? AGE_W'(1) : ((fb_age  == AGE_MAX) ? AGE_MAX : fb_age  + AGE_W'(1));
      ref_age <= ref_p ? AGE_W'(1) : ((ref_age == AGE_MAX) ? AGE_MAX : ref_age + AGE_W'(1));
      if (force_low) begin
        streak  <= '0;
        locked  <= 1'b0;
        waiting <= 1'b0;
      end else begin
        streak  <= streak_n;
        locked  <= (streak_n == RUN_MAX);
        waiting <= wait_n;
      end
    end
  end
endmodule

// File: rtl/chdiv_synth.sv
module chdiv_synth
  import chdiv_pkg::*;
#(
  parameter int VARIANT    = 0,
  parameter int REF_CLK_HZ = 10_240_000,
  parameter int STEP_HZ    = 5000,
  parameter int WIN_W      = 4,
  parameter int LOCK_RUN   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] ch_code,
  input  logic              tx_mode,
  input  logic              vco_tick,
  input  logic              ref_tick,
  input  logic [WIN_W-1:0]  lock_window,
  output logic              fb_pulse,
  output logic              ref_pulse,
  output logic              lock
);
  localparam int REF_DIV = REF_CLK_HZ / STEP_HZ;
  localparam int REF_W   = $clog2(REF_DIV + 1);

  logic [DIV_W-1:0]  div_req, fb_div, fb_rem;
  logic [REF_W-1:0]  ref_div, ref_rem;
  logic [CODE_W-1:0] held_ch;
  logic              code_bad, fb_tc, ref_tc, good_evt, bad_evt;

  chdiv_select #(.VARIANT(VARIANT)) u_sel (
    .clk(clk), .rst_n(rst_n), .ch_code(ch_code), .tx_mode(tx_mode),
    .div_req(div_req), .code_bad(code_bad), .held_ch(held_ch)
  );

  chdiv_counter #(.W(DIV_W), .INIT_DIV(rx_div(VARIANT, CH_FIRST))) u_fb_div (
    .clk(clk), .rst_n(rst_n), .tick(vco_tick), .div_in(div_req),
    .pulse(fb_pulse), .tc(fb_tc), .cur_div(fb_div), .remaining(fb_rem)
  );

  chdiv_counter #(.W(REF_W), .INIT_DIV(REF_W'(REF_DIV))) u_ref_div (
    .clk(clk), .rst_n(rst_n), .tick(ref_tick), .div_in(REF_W'(REF_DIV)),
    .pulse(ref_pulse), .tc(ref_tc), .cur_div(ref_div), .remaining(ref_rem)
  );

  chdiv_lock #(.WIN_W(WIN_W), .LOCK_RUN(LOCK_RUN)) u_lock (
    .clk(clk), .rst_n(rst_n), .fb_p(fb_pulse), .ref_p(ref_pulse),
    .force_low(code_bad), .window(lock_window), .locked(lock),
    .good_evt(good_evt), .bad_evt(bad_evt)
  );
endmodule

// File: rtl/chdiv_synth_chk.sv
module chdiv_synth_chk
  import chdiv_pkg::*;
#(
  parameter int VARIANT = 0,
  parameter int REF_W   = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fb_pulse,
  input logic              ref_pulse,
  input logic              lock,
  input logic              fb_tc,
  input logic              ref_tc,
  input logic              code_bad,
  input logic              good_evt,
  input logic              bad_evt,
  input logic [DIV_W-1:0]  fb_div,
  input logic [DIV_W-1:0]  fb_rem,
  input logic [REF_W-1:0]  ref_div,
  input logic [REF_W-1:0]  ref_rem,
  input logic [CODE_W-1:0] held_ch
);
  localparam logic [DIV_W-1:0] DIV_LO = rx_div(VARIANT, CH_FIRST);
  localparam logic [DIV_W-1:0] DIV_HI = rx_div(VARIANT, CH_LAST) + DIV_W'(TX_OFFSET);

  // R1
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_div >= DIV_LO) && (fb_div <= DIV_HI));
  // R4
  held_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_ch >= CODE_W'(CH_FIRST)) && (held_ch <= CODE_W'(CH_LAST)));
  // R5
  bad_code_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_bad |=> !lock);
  // R6
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fb_tc |=> $stable(fb_div));
  // R6
  fb_rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_rem < fb_div);
  // R7
  fb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse);
  // R8
  ref_rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_rem < ref_div);
  // R8
  ref_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tc |=> ref_pulse ##1 !ref_pulse);
  // R9
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(good_evt));
  // R10
  miss_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_evt |=> !lock);
endmodule

bind chdiv_synth chdiv_synth_chk #(.VARIANT(VARIANT), .REF_W(REF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fb_pulse(fb_pulse), .ref_pulse(ref_pulse),
  .lock(lock), .fb_tc(fb_tc), .ref_tc(ref_tc), .code_bad(code_bad),
  .good_evt(good_evt), .bad_evt(bad_evt), .fb_div(fb_div), .fb_rem(fb_rem),
  .ref_div(ref_div), .ref_rem(ref_rem), .held_ch(held_ch)
);

// File: tb/chdiv_synth_tb.sv
module chdiv_synth_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] ch, alt_ch;
  logic       tr, alt_tr, vco_tick, ref_tick, gate;
  logic [3:0] win;
  logic       fb, rf, lk, afb, arf, alk;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  chdiv_synth #(.VARIANT(0), .REF_CLK_HZ(16_270_000), .STEP_HZ(5000), .WIN_W(4), .LOCK_RUN(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .ch_code(ch), .tx_mode(tr), .vco_tick(vco_tick),
    .ref_tick(ref_tick), .lock_window(win), .fb_pulse(fb), .ref_pulse(rf), .lock(lk)
  );

  chdiv_synth #(.VARIANT(1), .REF_CLK_HZ(16_905_000), .STEP_HZ(5000), .WIN_W(4), .LOCK_RUN(16)) u_alt (
    .clk(clk), .rst_n(rst_n), .ch_code(alt_ch), .tx_mode(alt_tr), .vco_tick(vco_tick),
    .ref_tick(ref_tick), .lock_window(win), .fb_pulse(afb), .ref_pulse(arf), .lock(alk)
  );

  initial begin
    vco_tick = 1'b1;
    ref_tick = 1'b1;
    forever begin
      @(negedge clk);
      ref_tick <= 1'b1;
      vco_tick <= gate ? ~vco_tick : 1'b1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic sig(input int sel);
    case (sel)
      0: return fb;
      1: return rf;
      2: return afb;
      default: return arf;
    endcase
  endfunction

  task automatic wait_pulse(input int sel);
    do @(negedge clk); while (!sig(sel));
  endtask

  task automatic count_to_next(input int sel, output int per);
    per = 0;
    do begin @(negedge clk); per++; end while (!sig(sel));
  endtask

  task automatic measure(input int sel, output int per);
    wait_pulse(sel);
    count_to_next(sel, per);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; ch = 8'd1; alt_ch = 8'd1; tr = 1'b0; alt_tr = 1'b0;
    gate = 1'b0; win = 4'd4;
    repeat (5) @(negedge clk);
    check("R11 fb_pulse in reset", int'(fb), 0);
    check("R11 ref_pulse in reset", int'(rf), 0);
    check("R11 lock in reset", int'(lk), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 first tick pulse", int'(fb), 1);
  endtask

  task automatic t_lock;
    for (int i = 1; i < 14; i++) wait_pulse(1);
    repeat (3) @(negedge clk);
    check("R9 lock low after 14 periods", int'(lk), 0);
    check("R9 alt lock low early", int'(alk), 0);
    for (int i = 0; i < 3; i++) wait_pulse(1);
    repeat (3) @(negedge clk);
    check("R9 lock high after 17 periods", int'(lk), 1);
    check("R9 alt lock high", int'(alk), 1);
  endtask

  task automatic t_base_periods;
    int p0, p1, p2;
    fork
      measure(0, p0);
      measure(1, p1);
      measure(2, p2);
    join
    check("R11 R1 ch1 rx period", p0, 3254);
    check("R8 ref period", p1, 3254);
    check("R3 alt ch1 rx period", p2, 3381);
  endtask

  task automatic t_drift_and_bad;
    ch = 8'd2;
    alt_ch = 8'd0;
    repeat (3) @(negedge clk);
    check("R5 bad code drops lock", int'(alk), 0);
    for (int i = 0; i < 3; i++) wait_pulse(0);
    repeat (3) @(negedge clk);
    check("R9 lock held at offset 4", int'(lk), 1);
    wait_pulse(0);
    repeat (3) @(negedge clk);
    check("R10 lock lost at offset 6", int'(lk), 0);
  endtask

  task automatic t_step(input int dch, input logic dtr, input int dexp, input string dreq,
                        input int ach, input logic atr, input int aexp, input string areq);
    int pd, pa;
    ch = 8'(dch); tr = dtr; alt_ch = 8'(ach); alt_tr = atr;
    fork
      measure(0, pd);
      measure(2, pa);
    join
    check(dreq, pd, dexp);
    check(areq, pa, aexp);
  endtask

  task automatic t_no_truncate;
    int per;
    wait_pulse(0);
    per = 0;
    do begin
      @(negedge clk);
      per++;
      if (per == 100) begin ch = 8'd40; tr = 1'b0; end
    end while (!fb);
    check("R6 running period keeps old N", per, 3345);
    count_to_next(0, per);
    check("R6 next period uses new N", per, 3342);
  endtask

  task automatic t_gated;
    int per;
    gate = 1'b1;
    measure(0, per);
    check("R7 half-rate ticks double period", per, 6684);
    gate = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_lock();
    t_base_periods();
    t_drift_and_bad();
    t_step(2, 1'b0, 3256, "R1 ch2 rx", 0, 1'b0, 3381, "R4 alt code 0 keeps divisor");
    t_step(22, 1'b0, 3306, "R1 ch22 rx", 41, 1'b0, 3381, "R4 alt code 41 keeps divisor");
    t_step(23, 1'b0, 3312, "R1 ch23 rx", 40, 1'b0, 3459, "R3 alt ch40 rx");
    t_step(24, 1'b0, 3308, "R1 ch24 rx", 255, 1'b0, 3459, "R4 alt code 255 keeps divisor");
    t_step(40, 1'b1, 3433, "R2 ch40 tx", 40, 1'b1, 3550, "R3 R2 alt ch40 tx");
    t_step(1, 1'b1, 3345, "R2 ch1 tx", 2, 1'b0, 3383, "R3 alt ch2 rx");
    t_no_truncate();
    t_gated();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule